// File: doc/BRIEF.md
# Cycle-Level Activity Power Estimator

This block sits beside a processor timing model and turns two architectural activity signals into a power figure for every cycle that is sampled. The first signal is the set of per-way bank enables of a set-associative cache. A read lights every way of the set, and a write lights only the target way. The second signal is the register-file write port. Its data bus fans out to every register, so each bit that toggles on it costs energy, whichever register is actually written.

In each sampled cycle the block counts the asserted bank enables (X) and the bits that differ between the current and the previous write-data word (Y). It then forms a*X + b*Y + c, where c stands for all the remaining logic. The coefficients are unsigned Q8.8 values loaded through a small write-only configuration port. The result is registered with a valid flag. The block also keeps a saturating energy sum and a saturating count of sampled cycles, so average power is the sum divided by the count. A clear pulse zeroes both.

Top module: `act_power_est`

## Requirements
- R1: After reset, `est_vld` is 0, and `est`, `energy` and `cycles` are 0. All three coefficients and the mode bit are 0, so a sampled cycle before any configuration yields an estimate of 0.
- R2: X equals the number of asserted bits of `bank_en`: WAYS for an all-ways read and 1 for a single-way write.
- R3: Y equals the number of bit positions in which `rf_wdata` differs from the previous-data register. That register resets to 0.
- R4: In free mode (mode bit 0), `rf_we` has no effect. Y is counted and the previous-data register loads `rf_wdata` in every sampled cycle.
- R5: In gated mode (mode bit 1), a sampled cycle with `rf_we` low gives Y = 0 and leaves the previous-data register unchanged. With `rf_we` high it behaves as in free mode.
- R6: A cycle with `smp_vld` high places a*X + b*Y + c on `est` after the next rising edge, and `est_vld` is then 1. After a cycle with `smp_vld` low, `est_vld` is 0 and `est` holds its value.
- R7: A write with `cfg_we` high selects a register with `cfg_addr`: 0 = a, 1 = b, 2 = c, 3 = mode (bit 0 of `cfg_wdata`). A sample taken in the same cycle as the write still uses the old value. The new value applies from the next cycle.
- R8: Each sampled cycle adds its estimate to `energy`. The sum sticks at all ones instead of wrapping.
- R9: Each sampled cycle adds 1 to `cycles`. The count sticks at all ones instead of wrapping.
- R10: `clr` zeroes `energy` and `cycles` at the next edge. This takes priority over a sample in the same cycle, whose contribution is dropped, while `est` still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | The activity inputs are valid this cycle |
| bank_en | input | WAYS | Per-way cache bank enables |
| rf_we | input | 1 | Register-file write enable |
| rf_wdata | input | DATA_W | Register-file write data bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | COEF_W | Configuration write data |
| clr | input | 1 | Clear pulse for the energy sum and the cycle count |
| est | output | EST_W | Registered per-cycle estimate, 8 fractional bits |
| est_vld | output | 1 | `est` holds a fresh estimate |
| energy | output | ACC_W | Saturating sum of estimates |
| cycles | output | CNT_W | Saturating count of sampled cycles |

## Verification
Two pairs of events can fall in the same cycle. A coefficient write can meet a sample, and a clear can meet a sample. The bench drives each pair together on one edge. It then expects the estimate from the old coefficient, with the new one appearing only on the following cycle, and it expects a zero sum and count even though an estimate was produced. Every other cycle is judged by a bench-side arithmetic model of X, Y, the previous-data word, the sum and the count, swept over all 256 bank-enable patterns and long data sequences in both modes.

// File: rtl/ape_pkg.sv
// Shared definitions for the activity power estimator.
// Assumes a two-bit configuration select.
package ape_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_MODE = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/ape_cfg.sv
// Coefficient and mode registers, written one at a time.
// Assumes a write lands at the edge and is used from the next cycle on.
module ape_cfg #(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [COEF_W-1:0] wdata,
    output logic [COEF_W-1:0] coef_a,
    output logic [COEF_W-1:0] coef_b,
    output logic [COEF_W-1:0] coef_c,
    output logic              gated
);
    import ape_pkg::*;

    // Load the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_a <= '0;
            coef_b <= '0;
            coef_c <= '0;
            gated  <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(addr))
                SEL_A:    coef_a <= wdata;
                SEL_B:    coef_b <= wdata;
                SEL_C:    coef_c <= wdata;
                default:  gated  <= wdata[0];
            endcase
        end
    end
endmodule

// File: rtl/ape_activity.sv
// Computes the two activity terms: the bank-enable population count and the
// Hamming distance on the write-data bus. Holds the previous-data word.
// Assumes that in gated mode the bus carries meaning only when rf_we is high.
module ape_activity #(
    parameter int WAYS   = 8,
    parameter int DATA_W = 32,
    localparam int XW    = $clog2(WAYS + 1),
    localparam int YW    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              gated,
    input  logic [WAYS-1:0]   bank_en,
    input  logic              rf_we,
    input  logic [DATA_W-1:0] rf_wdata,
    output logic [XW-1:0]     x_cnt,
    output logic [YW-1:0]     y_cnt
);
    logic [DATA_W-1:0] prev_q;
    logic [DATA_W-1:0] diff;
    logic              track;

    assign track = !gated || rf_we;
    assign diff  = rf_wdata ^ prev_q;

    // Count the asserted bank enables.
    always_comb begin
        x_cnt = '0;
        for (int i = 0; i < WAYS; i++) x_cnt = x_cnt + XW'(bank_en[i]);
    end

    // Count the toggled data bits, or none while gated and not writing.
    always_comb begin
        y_cnt = '0;
        for (int i = 0; i < DATA_W; i++) y_cnt = y_cnt + YW'(diff[i]);
        if (!track) y_cnt = '0;
    end

    // Remember the last bus value seen in a counted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          prev_q <= '0;
        else if (smp && track) prev_q <= rf_wdata;
    end
endmodule

// File: rtl/ape_sat_acc.sv
// Saturating accumulator with a clear that takes priority over an add.
// Assumes an IN_W no wider than W for a meaningful sum.
module ape_sat_acc #(
    parameter int W    = 48,
    parameter int IN_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [IN_W-1:0] inc,
    output logic [W-1:0]    q
);
    logic [W:0] sum;

    assign sum = {1'b0, q} + (W+1)'(inc);

    // Add, or pin at all ones when the add carries out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= sum[W] ? '1 : sum[W-1:0];
    end
endmodule

// File: rtl/act_power_est.sv
// Linear per-cycle power estimate from cache bank activity and register-file
// write-bus toggles: est = a*X + b*Y + c, coefficients Q8.8.
// Assumes EST_W holds the worst-case sum (the default does).
module act_power_est #(
    parameter int WAYS   = 8,
    parameter int DATA_W = 32,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 48,
    parameter int CNT_W  = 32,
    parameter int EST_W  = COEF_W + $clog2(WAYS + DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [WAYS-1:0]   bank_en,
    input  logic              rf_we,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              clr,
    output logic [EST_W-1:0]  est,
    output logic              est_vld,
    output logic [ACC_W-1:0]  energy,
    output logic [CNT_W-1:0]  cycles
);
    localparam int XW = $clog2(WAYS + 1);
    localparam int YW = $clog2(DATA_W + 1);

    logic [COEF_W-1:0] coef_a, coef_b, coef_c;
    logic              gated;
    logic [XW-1:0]     x_cnt;
    logic [YW-1:0]     y_cnt;
    logic [EST_W-1:0]  est_d;

    ape_cfg #(.COEF_W(COEF_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .coef_a(coef_a), .coef_b(coef_b),
        .coef_c(coef_c), .gated(gated)
    );

    ape_activity #(.WAYS(WAYS), .DATA_W(DATA_W)) u_act (
        .clk(clk), .rst_n(rst_n), .smp(smp_vld), .gated(gated),
        .bank_en(bank_en), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .x_cnt(x_cnt), .y_cnt(y_cnt)
    );

    // Weighted sum of the two activity terms plus the constant.
    always_comb begin
        est_d = EST_W'(coef_a) * EST_W'(x_cnt)
              + EST_W'(coef_b) * EST_W'(y_cnt)
              + EST_W'(coef_c);
    end

    // Register the estimate and flag which cycles carry a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est     <= '0;
            est_vld <= 1'b0;
        end else begin
            est_vld <= smp_vld;
            if (smp_vld) est <= est_d;
        end
    end

    ape_sat_acc #(.W(ACC_W), .IN_W(EST_W)) u_energy (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(smp_vld),
        .inc(est_d), .q(energy)
    );

    ape_sat_acc #(.W(CNT_W), .IN_W(1)) u_cycles (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(smp_vld),
        .inc(1'b1), .q(cycles)
    );
endmodule

// File: rtl/ape_chk.sv
// Port-level temporal checks for act_power_est, attached with bind.
module ape_chk #(
    parameter int EST_W = 22,
    parameter int ACC_W = 48,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             clr,
    input logic [EST_W-1:0] est,
    input logic             est_vld,
    input logic [ACC_W-1:0] energy,
    input logic [CNT_W-1:0] cycles
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!est_vld && est == '0 && energy == '0 && cycles == '0));

    // R6
    vld_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> est_vld == $past(smp_vld));

    // R6
    est_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(smp_vld)) |-> $stable(est));

    // R8
    energy_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr)) |-> energy >= $past(energy));

    // R9
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $past(smp_vld) && $past(cycles) != '1)
        |-> cycles == $past(cycles) + CNT_W'(1));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (energy == '0 && cycles == '0));
endmodule

bind act_power_est ape_chk #(.EST_W(EST_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_act_power_est.sv
// Sweeps a small configuration of the estimator against an arithmetic model.
module sim_act_power_est;
    localparam int WAYS   = 8;
    localparam int DATA_W = 8;
    localparam int COEF_W = 16;
    localparam int ACC_W  = 24;
    localparam int CNT_W  = 6;
    localparam int EW     = COEF_W + $clog2(WAYS + DATA_W + 2);
    localparam longint MAXE = (64'd1 << ACC_W) - 1;
    localparam longint MAXC = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic [WAYS-1:0]   bank_en = '0;
    logic              rf_we = 1'b0;
    logic [DATA_W-1:0] rf_wdata = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [COEF_W-1:0] cfg_wdata = '0;
    logic              clr = 1'b0;
    logic [EW-1:0]     est;
    logic              est_vld;
    logic [ACC_W-1:0]  energy;
    logic [CNT_W-1:0]  cycles;

    int errors = 0;
    int checks = 0;

    // Bench model state
    longint a_m = 0, b_m = 0, c_m = 0, est_m = 0, energy_m = 0, cnt_m = 0;
    logic   gated_m = 1'b0;
    logic [DATA_W-1:0] prev_m = '0;

    always #10 clk = ~clk;

    act_power_est #(.WAYS(WAYS), .DATA_W(DATA_W), .COEF_W(COEF_W),
                    .ACC_W(ACC_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .bank_en(bank_en),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .clr(clr),
        .est(est), .est_vld(est_vld), .energy(energy), .cycles(cycles)
    );

    function automatic longint pc(logic [31:0] v);
        longint n = 0;
        for (int i = 0; i < 32; i++) n += longint'(v[i]);
        return n;
    endfunction

    task automatic chk(string req, longint act, longint exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare after the rise.
    task automatic cyc(string tag, logic smp, logic [WAYS-1:0] be, logic we,
                       logic [DATA_W-1:0] wd, logic cl,
                       logic cw, logic [1:0] ca, logic [COEF_W-1:0] cd);
        longint x, y, e;
        smp_vld = smp; bank_en = be; rf_we = we; rf_wdata = wd; clr = cl;
        cfg_we = cw; cfg_addr = ca; cfg_wdata = cd;
        @(posedge clk);
        x = pc(32'(be));
        y = (gated_m && !we) ? 0 : pc(32'(wd ^ prev_m));
        e = a_m * x + b_m * y + c_m;
        if (smp) begin
            est_m = e;
            if (!gated_m || we) prev_m = wd;
        end
        if (cl) begin
            energy_m = 0; cnt_m = 0;
        end else if (smp) begin
            energy_m = (energy_m + e > MAXE) ? MAXE : energy_m + e;
            cnt_m    = (cnt_m + 1 > MAXC) ? MAXC : cnt_m + 1;
        end
        if (cw) begin
            case (ca)
                2'd0: a_m = longint'(cd);
                2'd1: b_m = longint'(cd);
                2'd2: c_m = longint'(cd);
                default: gated_m = cd[0];
            endcase
        end
        #1;
        chk("R6 valid", longint'(est_vld), longint'(smp));
        chk(tag, longint'(est), est_m);
        chk(cl ? "R10 energy" : "R8 energy", longint'(energy), energy_m);
        chk(cl ? "R10 cycles" : "R9 cycles", longint'(cycles), cnt_m);
        @(negedge clk);
        smp_vld = 1'b0; clr = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wcfg(logic [1:0] ad, logic [COEF_W-1:0] d);
        cyc("R7 cfg", 1'b0, '0, 1'b0, rf_wdata, 1'b0, 1'b1, ad, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset
        chk("R1 est_vld", longint'(est_vld), 0);
        chk("R1 est", longint'(est), 0);
        chk("R1 energy", longint'(energy), 0);
        chk("R1 cycles", longint'(cycles), 0);
        @(negedge clk);
        cyc("R1 zero coefs", 1'b1, '1, 1'b1, 8'hFF, 1'b0, 1'b0, 2'd0, '0);

        // R7: load coefficients, then the R2 sweep with a constant bus (Y = 0)
        wcfg(2'd0, 16'h0180);
        wcfg(2'd1, 16'h0040);
        wcfg(2'd2, 16'h0100);
        for (int p = 0; p < 256; p++)
            cyc("R2 bank count", 1'b1, WAYS'(p), 1'b0, 8'hFF, 1'b0, 1'b0, 2'd0, '0);
        cyc("R2 all-way read", 1'b1, 8'hFF, 1'b0, 8'hFF, 1'b0, 1'b0, 2'd0, '0);
        cyc("R2 one-way write", 1'b1, 8'h10, 1'b0, 8'hFF, 1'b0, 1'b0, 2'd0, '0);

        // R3 and R4: free mode, bus toggles counted with or without rf_we
        for (int i = 0; i < 256; i++)
            cyc((i < 128) ? "R3 hamming" : "R4 free mode", 1'b1, '0, (i < 128),
                DATA_W'(i * 37 + 11), 1'b0, 1'b0, 2'd0, '0);
        cyc("R3 flip all", 1'b1, '0, 1'b1, ~rf_wdata, 1'b0, 1'b0, 2'd0, '0);

        // R6: idle cycles keep the estimate and drop the valid flag
        for (int i = 0; i < 3; i++)
            cyc("R6 hold", 1'b0, 8'hFF, 1'b1, 8'h5A, 1'b0, 1'b0, 2'd0, '0);

        // R5: gated mode, non-write cycles neither count nor update
        wcfg(2'd3, 16'h0001);
        for (int i = 0; i < 200; i++)
            cyc("R5 gated", 1'b1, WAYS'(i), (i % 3 == 0), DATA_W'(i * 91 + 5),
                1'b0, 1'b0, 2'd0, '0);

        // R7: coefficient write in the same cycle as a sample
        cyc("R7 old coef", 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b1, 2'd0, 16'h0200);
        cyc("R7 new coef", 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, '0);
        wcfg(2'd3, 16'h0000);

        // R10: clear together with a sample
        cyc("R10 est updates", 1'b1, 8'h0F, 1'b1, 8'h33, 1'b1, 1'b0, 2'd0, '0);
        cyc("R10 after clear", 1'b1, 8'h01, 1'b1, 8'h3C, 1'b0, 1'b0, 2'd0, '0);

        // R8 and R9: maximum coefficients drive both totals into saturation
        wcfg(2'd0, 16'hFFFF);
        wcfg(2'd1, 16'hFFFF);
        wcfg(2'd2, 16'hFFFF);
        for (int i = 0; i < 80; i++)
            cyc("R8 saturate", 1'b1, 8'hFF, 1'b1, (i % 2 == 0) ? 8'hFF : 8'h00,
                1'b0, 1'b0, 2'd0, '0);
        chk("R8 pinned", longint'(energy), MAXE);
        chk("R9 pinned", longint'(cycles), MAXC);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule